// File: doc/BRIEF.md
# Scaler Request Validator and Allocator

This block decides whether a scaling request from one of several users (display planes or the pipe itself) may be granted, and keeps track of which users currently hold one of a small pool of scalers. Each request names the user, the source and destination width and height, and a set of mode flags. The flags are: the source is semiplanar YUV, the output is interlaced, the user is being detached, a hint that scaling is wanted even at equal sizes, and a selector for the older or newer size limits.

The block works out whether scaling is needed at all. It then applies the mode and size rules in a fixed priority order and either grants, keeps or releases a scaler for that user. One cycle after the request strobe it returns accept or reject, a reason code, and the scaler the user now holds. The per-user hold bitmask and the per-scaler busy map are visible at all times, so a later register-programming stage can read them. That programming stage is a separate block.

Top module: `scale_grant_unit`

## Requirements
- R1: Scaling is needed when source width differs from destination width, or source height differs from destination height, or the scale hint is set; with equal sizes and no hint the request takes the release path of R2.
- R2: On force-detach, or when no scaling is needed, the request is accepted with reason 0. The user's bit in `user_mask` is cleared and any scaler it held is marked free in `scaler_busy`. `rsp_hold` is 0 and `rsp_id` carries the released scaler, or 0 if none was held.
- R3: A request that needs scaling and is not a detach is rejected with reason 1 when the interlaced flag is set.
- R4: For a semiplanar YUV source, a source width or source height below 16 rejects the request with reason 2.
- R5: Any of the four dimensions below 8 rejects the request with reason 3.
- R6: With `gen_wide`=0, any dimension above 4096 rejects with reason 4. With `gen_wide`=1, widths up to 5120 are allowed and heights stay capped at 4096.
- R7: A request that passes every check is accepted with reason 0. It sets the user's bit in `user_mask` and returns `rsp_hold`=1 with the held scaler in `rsp_id`.
- R8: A passing user that holds no scaler gets the lowest-numbered free scaler. A user that already holds a scaler keeps the same one. If no scaler is free, the request is rejected with reason 5.
- R9: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R10: A rejected request changes neither `user_mask` nor `scaler_busy`. Its `rsp_hold` and `rsp_id` report the user's unchanged holding (id 0 when nothing is held).
- R11: A user index of N_USERS or above is rejected with reason 6, ahead of every other rule.
- R12: After reset, `rsp_valid`, `user_mask` and `scaler_busy` are all zero.
- R13: When several rules fail at once, the reason reported follows the order bad user, release, interlaced, YUV minimum, minimum, maximum, no free scaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_user | input | UW (3) | Requesting user index |
| src_w | input | DIM_W (14) | Source width |
| src_h | input | DIM_W (14) | Source height |
| dst_w | input | DIM_W (14) | Destination width |
| dst_h | input | DIM_W (14) | Destination height |
| yuv_semi | input | 1 | Source is semiplanar YUV |
| interlaced | input | 1 | Output timing is interlaced |
| force_detach | input | 1 | Release the user's scaler unconditionally |
| scale_hint | input | 1 | Scaling wanted even at equal sizes |
| gen_wide | input | 1 | Select the newer, wider size limits |
| rsp_valid | output | 1 | Decision strobe |
| rsp_accept | output | 1 | Request accepted |
| rsp_reason | output | 3 | Reason code (0 accepted) |
| rsp_user | output | UW (3) | User the decision belongs to |
| rsp_hold | output | 1 | User holds a scaler after the decision |
| rsp_id | output | IW (1) | Held or released scaler index |
| user_mask | output | N_USERS (5) | One bit per user holding a scaler |
| scaler_busy | output | N_SCALERS (2) | One bit per scaler in use |

## Verification
On every cycle the assertions check several properties. The decision strobe follows the request strobe by exactly one cycle. The accept flag agrees with a zero reason. The number of users holding a scaler equals the number of busy scalers. A reject leaves both maps unchanged. An accepted decision leaves the user's mask bit equal to `rsp_hold`, the free-scaler pick is at most one-hot, and a release clears the freed scaler. Only the bench's scenarios can show the rest. That covers the exact boundary values (7/8, 15/16, 4096/4097, 5120/5121), the dependence of the width cap on the generation select, the priority among several failing rules, and the choice of the lowest free scaler after releases in various orders.

// File: rtl/sga_pkg.sv
package sga_pkg;
   typedef enum logic [2:0] {
      RSN_OK        = 3'd0,
      RSN_INTERLACE = 3'd1,
      RSN_YUV_MIN   = 3'd2,
      RSN_DIM_MIN   = 3'd3,
      RSN_DIM_MAX   = 3'd4,
      RSN_NO_FREE   = 3'd5,
      RSN_BAD_USER  = 3'd6
   } rsn_e;
endpackage

// File: rtl/sga_limit_check.sv
module sga_limit_check
   import sga_pkg::*;
#(
   parameter int DIM_W       = 14,
   parameter int MIN_DIM     = 8,
   parameter int MIN_YUV     = 16,
   parameter int MAX_H       = 4096,
   parameter int MAX_W_BASE  = 4096,
   parameter int MAX_W_WIDE  = 5120,
   parameter bit WIDE_GEN_EN = 1'b1
) (
   input  logic [DIM_W-1:0] src_w,
   input  logic [DIM_W-1:0] src_h,
   input  logic [DIM_W-1:0] dst_w,
   input  logic [DIM_W-1:0] dst_h,
   input  logic             yuv_semi,
   input  logic             interlaced,
   input  logic             scale_hint,
   input  logic             gen_wide,
   output logic             need,
   output rsn_e             rsn
);
   localparam logic [DIM_W-1:0] MIN_D  = DIM_W'(MIN_DIM);
   localparam logic [DIM_W-1:0] MIN_Y  = DIM_W'(MIN_YUV);
   localparam logic [DIM_W-1:0] CAP_H  = DIM_W'(MAX_H);
   localparam logic [DIM_W-1:0] CAP_WB = DIM_W'(MAX_W_BASE);
   localparam logic [DIM_W-1:0] CAP_WW = DIM_W'(MAX_W_WIDE);

   if (MAX_W_WIDE >= (1 << DIM_W) || MAX_H >= (1 << DIM_W)) begin : g_bad_cap
      $error("size caps do not fit DIM_W");
   end
   if (MIN_YUV < MIN_DIM) begin : g_bad_min
      $error("YUV minimum below plain minimum");
   end

   logic [DIM_W-1:0] w_cap;

   if (WIDE_GEN_EN) begin : g_wide
      assign w_cap = gen_wide ? CAP_WW : CAP_WB;
   end else begin : g_base
      logic unused_gen;
      assign unused_gen = gen_wide;
      assign w_cap      = CAP_WB;
   end

   logic yuv_small, too_small, too_big;

   always_comb begin
      need      = (src_w != dst_w) || (src_h != dst_h) || scale_hint;
      yuv_small = yuv_semi && ((src_w < MIN_Y) || (src_h < MIN_Y));
      too_small = (src_w < MIN_D) || (src_h < MIN_D) ||
                  (dst_w < MIN_D) || (dst_h < MIN_D);
      too_big   = (src_w > w_cap) || (dst_w > w_cap) ||
                  (src_h > CAP_H) || (dst_h > CAP_H);
      if (interlaced)      rsn = RSN_INTERLACE;
      else if (yuv_small)  rsn = RSN_YUV_MIN;
      else if (too_small)  rsn = RSN_DIM_MIN;
      else if (too_big)    rsn = RSN_DIM_MAX;
      else                 rsn = RSN_OK;
   end

   // R13: interlace outranks every size rule
   always_comb begin
      a_interlace_first_r13: assert (!interlaced || rsn == RSN_INTERLACE);
   end
endmodule

// File: rtl/sga_free_pick.sv
module sga_free_pick #(
   parameter int N_SCALERS = 2,
   localparam int IW = (N_SCALERS > 1) ? $clog2(N_SCALERS) : 1
) (
   input  logic [N_SCALERS-1:0] busy,
   output logic [N_SCALERS-1:0] grant,
   output logic                 any_free,
   output logic [IW-1:0]        pick_id
);
   logic [N_SCALERS:0] seen;
   assign seen[0] = 1'b0;

   for (genvar s = 0; s < N_SCALERS; s++) begin : g_slot
      assign grant[s]  = !busy[s] && !seen[s];
      assign seen[s+1] = seen[s] | !busy[s];
   end

   assign any_free = seen[N_SCALERS];

   always_comb begin
      pick_id = '0;
      for (int s = 0; s < N_SCALERS; s++) begin
         if (grant[s]) pick_id = IW'(s);
      end
   end

   // R8: at most one scaler is offered, and only when one is free
   always_comb begin
      a_grant_onehot_r8: assert ($onehot0(grant) && (any_free == (grant != '0)));
   end
endmodule

// File: rtl/sga_hold_table.sv
module sga_hold_table #(
   parameter int N_USERS   = 5,
   parameter int N_SCALERS = 2,
   parameter int UW        = 3,
   parameter int IW        = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 set_en,
   input  logic                 clr_en,
   input  logic [UW-1:0]        user,
   input  logic [IW-1:0]        set_id,
   output logic [N_USERS-1:0]   user_mask,
   output logic [N_SCALERS-1:0] busy,
   output logic                 cur_held,
   output logic [IW-1:0]        cur_id
);
   logic [IW-1:0] hid_w [N_USERS];

   for (genvar u = 0; u < N_USERS; u++) begin : g_user
      logic          held_q;
      logic [IW-1:0] hid_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            held_q <= 1'b0;
            hid_q  <= '0;
         end else if (user == UW'(u)) begin
            if (set_en) begin
               held_q <= 1'b1;
               hid_q  <= set_id;
            end else if (clr_en) begin
               held_q <= 1'b0;
            end
         end
      end
      assign user_mask[u] = held_q;
      assign hid_w[u]     = hid_q;
   end

   always_comb begin
      cur_held = 1'b0;
      cur_id   = '0;
      for (int u = 0; u < N_USERS; u++) begin
         if (user == UW'(u)) begin
            cur_held = user_mask[u];
            cur_id   = hid_w[u];
         end
      end
   end

   for (genvar s = 0; s < N_SCALERS; s++) begin : g_scaler
      logic busy_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            busy_q <= 1'b0;
         else if (set_en && set_id == IW'(s))
            busy_q <= 1'b1;
         else if (clr_en && cur_held && cur_id == IW'(s))
            busy_q <= 1'b0;
      end
      assign busy[s] = busy_q;
   end

   // R2: a release frees the scaler the user held
   p_release_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && cur_held) |=> !busy[$past(cur_id)]);

   // R8: a grant marks its scaler busy
   p_grant_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> busy[$past(set_id)]);
endmodule

// File: rtl/scale_grant_unit.sv
module scale_grant_unit
   import sga_pkg::*;
#(
   parameter int N_USERS     = 5,
   parameter int N_SCALERS   = 2,
   parameter int DIM_W       = 14,
   parameter int MIN_DIM     = 8,
   parameter int MIN_YUV     = 16,
   parameter int MAX_H       = 4096,
   parameter int MAX_W_BASE  = 4096,
   parameter int MAX_W_WIDE  = 5120,
   parameter bit WIDE_GEN_EN = 1'b1,
   localparam int UW = (N_USERS > 1) ? $clog2(N_USERS) : 1,
   localparam int IW = (N_SCALERS > 1) ? $clog2(N_SCALERS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [UW-1:0]        req_user,
   input  logic [DIM_W-1:0]     src_w,
   input  logic [DIM_W-1:0]     src_h,
   input  logic [DIM_W-1:0]     dst_w,
   input  logic [DIM_W-1:0]     dst_h,
   input  logic                 yuv_semi,
   input  logic                 interlaced,
   input  logic                 force_detach,
   input  logic                 scale_hint,
   input  logic                 gen_wide,
   output logic                 rsp_valid,
   output logic                 rsp_accept,
   output logic [2:0]           rsp_reason,
   output logic [UW-1:0]        rsp_user,
   output logic                 rsp_hold,
   output logic [IW-1:0]        rsp_id,
   output logic [N_USERS-1:0]   user_mask,
   output logic [N_SCALERS-1:0] scaler_busy
);
   if (N_USERS < 1 || N_SCALERS < 1) begin : g_bad_count
      $error("N_USERS and N_SCALERS must be positive");
   end

   logic          need;
   rsn_e          chk_rsn;
   logic          user_ok;
   logic          any_free;
   logic [IW-1:0] pick_id;
   logic [N_SCALERS-1:0] grant;
   logic          cur_held;
   logic [IW-1:0] cur_id;

   if (N_USERS == (1 << UW)) begin : g_full_range
      assign user_ok = 1'b1;
   end else begin : g_part_range
      assign user_ok = req_user < UW'(N_USERS);
   end

   sga_limit_check #(
      .DIM_W(DIM_W), .MIN_DIM(MIN_DIM), .MIN_YUV(MIN_YUV), .MAX_H(MAX_H),
      .MAX_W_BASE(MAX_W_BASE), .MAX_W_WIDE(MAX_W_WIDE), .WIDE_GEN_EN(WIDE_GEN_EN)
   ) u_limit (
      .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
      .yuv_semi(yuv_semi), .interlaced(interlaced), .scale_hint(scale_hint),
      .gen_wide(gen_wide), .need(need), .rsn(chk_rsn)
   );

   sga_free_pick #(.N_SCALERS(N_SCALERS)) u_pick (
      .busy(scaler_busy), .grant(grant), .any_free(any_free), .pick_id(pick_id)
   );

   logic          set_en, clr_en;
   logic [IW-1:0] set_id;
   logic          d_accept, d_hold;
   rsn_e          d_rsn;
   logic [IW-1:0] d_id;

   always_comb begin
      set_en   = 1'b0;
      clr_en   = 1'b0;
      set_id   = '0;
      d_accept = 1'b0;
      d_rsn    = RSN_OK;
      d_hold   = cur_held;
      d_id     = cur_held ? cur_id : '0;
      if (!user_ok) begin
         d_rsn  = RSN_BAD_USER;
      end else if (force_detach || !need) begin
         d_accept = 1'b1;
         clr_en   = req_valid;
         d_hold   = 1'b0;
      end else if (chk_rsn != RSN_OK) begin
         d_rsn = chk_rsn;
      end else if (cur_held) begin
         d_accept = 1'b1;
         set_en   = req_valid;
         set_id   = cur_id;
      end else if (any_free) begin
         d_accept = 1'b1;
         set_en   = req_valid;
         set_id   = pick_id;
         d_hold   = 1'b1;
         d_id     = pick_id;
      end else begin
         d_rsn = RSN_NO_FREE;
      end
   end

   sga_hold_table #(
      .N_USERS(N_USERS), .N_SCALERS(N_SCALERS), .UW(UW), .IW(IW)
   ) u_table (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
      .user(req_user), .set_id(set_id), .user_mask(user_mask),
      .busy(scaler_busy), .cur_held(cur_held), .cur_id(cur_id)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_accept <= 1'b0;
         rsp_reason <= '0;
         rsp_user   <= '0;
         rsp_hold   <= 1'b0;
         rsp_id     <= '0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_accept <= d_accept;
            rsp_reason <= d_rsn;
            rsp_user   <= req_user;
            rsp_hold   <= d_hold;
            rsp_id     <= d_id;
         end
      end
   end

   // R9: one decision per strobe, one cycle later
   p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R7: accept and a zero reason go together
   p_accept_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_accept == (rsp_reason == 3'd0)));

   // R8: holders and busy scalers stay in step
   p_count_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(user_mask) == $countones(scaler_busy));

   // R10: a reject leaves both maps alone
   p_reject_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_accept) |->
         (user_mask == $past(user_mask) && scaler_busy == $past(scaler_busy)));

   // R2: after an accepted decision the mask bit matches rsp_hold
   p_hold_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_accept) |-> (user_mask[rsp_user] == rsp_hold));
endmodule

// File: tb/scale_grant_unit_bench.sv
module scale_grant_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NU = 5;
   localparam int NS = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_user = '0;
   logic [13:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
   logic        yuv_semi = 1'b0, interlaced = 1'b0, force_detach = 1'b0;
   logic        scale_hint = 1'b0, gen_wide = 1'b0;
   logic        rsp_valid, rsp_accept, rsp_hold;
   logic [2:0]  rsp_reason, rsp_user;
   logic [0:0]  rsp_id;
   logic [NU-1:0] user_mask;
   logic [NS-1:0] scaler_busy;

   scale_grant_unit u_scale_grant_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_user(req_user),
      .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
      .yuv_semi(yuv_semi), .interlaced(interlaced), .force_detach(force_detach),
      .scale_hint(scale_hint), .gen_wide(gen_wide),
      .rsp_valid(rsp_valid), .rsp_accept(rsp_accept), .rsp_reason(rsp_reason),
      .rsp_user(rsp_user), .rsp_hold(rsp_hold), .rsp_id(rsp_id),
      .user_mask(user_mask), .scaler_busy(scaler_busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   bit m_held [NU];
   int m_hid  [NU];
   bit m_busy [NS];
   bit prev_req = 0;
   bit cmp_on = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int mask_of_users();
      int m = 0;
      for (int u = 0; u < NU; u++) if (m_held[u]) m |= (1 << u);
      return m;
   endfunction

   function automatic int mask_of_busy();
      int m = 0;
      for (int s = 0; s < NS; s++) if (m_busy[s]) m |= (1 << s);
      return m;
   endfunction

   always @(posedge clk) prev_req <= req_valid;

   // every-cycle comparison of strobe and maps (R9, R8, R10)
   always @(negedge clk) begin
      if (cmp_on) begin
         chk("R9", "rsp_valid", int'(rsp_valid), int'(prev_req));
         chk("R8", "user_mask", int'(user_mask), mask_of_users());
         chk("R10", "scaler_busy", int'(scaler_busy), mask_of_busy());
      end
   end

   // called at a negedge; returns at the following negedge with req_valid low
   task automatic do_req(input string tag, input int u, input int sw, input int sh,
                         input int dw, input int dh, input bit yuv, input bit il,
                         input bit fd, input bit hint, input bit gen);
      bit e_acc, e_hold, nd, ok_u;
      int e_rsn, e_id, wcap, freeid;
      req_valid = 1; req_user = 3'(u);
      src_w = 14'(sw); src_h = 14'(sh); dst_w = 14'(dw); dst_h = 14'(dh);
      yuv_semi = yuv; interlaced = il; force_detach = fd; scale_hint = hint; gen_wide = gen;
      ok_u  = (u < NU);
      nd    = (sw != dw) || (sh != dh) || hint;
      wcap  = gen ? 5120 : 4096;
      e_acc = 0; e_rsn = 0;
      e_hold = ok_u ? m_held[u] : 0;
      e_id   = (ok_u && m_held[u]) ? m_hid[u] : 0;
      @(posedge clk);
      if (!ok_u) e_rsn = 6;
      else if (fd || !nd) begin
         e_acc = 1; e_hold = 0;
         if (m_held[u]) m_busy[m_hid[u]] = 0;
         m_held[u] = 0;
      end
      else if (il) e_rsn = 1;
      else if (yuv && (sw < 16 || sh < 16)) e_rsn = 2;
      else if (sw < 8 || sh < 8 || dw < 8 || dh < 8) e_rsn = 3;
      else if (sw > wcap || dw > wcap || sh > 4096 || dh > 4096) e_rsn = 4;
      else if (m_held[u]) begin e_acc = 1; e_hold = 1; end
      else begin
         freeid = -1;
         for (int s = NS - 1; s >= 0; s--) if (!m_busy[s]) freeid = s;
         if (freeid < 0) e_rsn = 5;
         else begin
            e_acc = 1; e_hold = 1; e_id = freeid;
            m_busy[freeid] = 1; m_held[u] = 1; m_hid[u] = freeid;
         end
      end
      @(negedge clk);
      req_valid = 0;
      chk(tag, "accept", int'(rsp_accept), int'(e_acc));
      chk(tag, "reason", int'(rsp_reason), e_rsn);
      chk(tag, "hold", int'(rsp_hold), int'(e_hold));
      chk(tag, "id", int'(rsp_id), e_id);
      chk(tag, "user", int'(rsp_user), u);
   endtask

   function automatic int pick_dim();
      case ($urandom_range(0, 8))
         0: return 7;    1: return 8;    2: return 15;
         3: return 16;   4: return 640;  5: return 4096;
         6: return 4097; 7: return 5120; default: return 5121;
      endcase
   endfunction

   initial begin
      for (int u = 0; u < NU; u++) begin m_held[u] = 0; m_hid[u] = 0; end
      for (int s = 0; s < NS; s++) m_busy[s] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R12", "rsp_valid", int'(rsp_valid), 0);
      chk("R12", "user_mask", int'(user_mask), 0);
      chk("R12", "scaler_busy", int'(scaler_busy), 0);
      cmp_on = 1;
      // R7 R8: first grant takes scaler 0
      do_req("R7", 0, 100, 100, 200, 200, 0, 0, 0, 0, 0);
      // R1: equal sizes, no hint -> release path
      do_req("R1", 1, 300, 200, 300, 200, 0, 0, 0, 0, 0);
      // R1: hint alone asks for scaling
      do_req("R1", 1, 300, 200, 300, 200, 0, 0, 0, 1, 0);
      // R8: pool exhausted
      do_req("R8", 2, 64, 64, 32, 32, 0, 0, 0, 0, 0);
      // R8: held user keeps its scaler
      do_req("R8", 1, 64, 64, 128, 128, 0, 0, 0, 0, 0);
      // R2: detach frees scaler 0
      do_req("R2", 0, 100, 100, 200, 200, 0, 0, 1, 0, 0);
      // R8: lowest free is scaler 0 again
      do_req("R8", 2, 64, 64, 32, 32, 0, 0, 0, 0, 0);
      // R2: detach with nothing held
      do_req("R2", 3, 64, 64, 32, 32, 0, 0, 1, 0, 0);
      // R3 and R13: interlace reported ahead of size faults
      do_req("R3", 3, 64, 64, 32, 32, 0, 1, 0, 0, 0);
      do_req("R13", 3, 4, 9000, 32, 32, 1, 1, 0, 0, 0);
      do_req("R3", 3, 64, 64, 64, 64, 0, 1, 0, 0, 0);
      // free everything for boundary tests
      do_req("R2", 1, 10, 10, 10, 10, 0, 0, 0, 0, 0);
      do_req("R2", 2, 10, 10, 20, 20, 0, 0, 1, 0, 0);
      // R4: YUV minimum
      do_req("R4", 3, 15, 64, 32, 32, 1, 0, 0, 0, 0);
      do_req("R4", 3, 64, 15, 32, 32, 1, 0, 0, 0, 0);
      do_req("R13", 3, 7, 64, 32, 32, 1, 0, 0, 0, 0);
      do_req("R4", 3, 16, 16, 32, 32, 1, 0, 0, 0, 0);
      do_req("R2", 3, 16, 16, 32, 32, 0, 0, 1, 0, 0);
      // R5: plain minimum
      do_req("R5", 4, 64, 64, 7, 64, 0, 0, 0, 0, 0);
      do_req("R5", 4, 64, 7, 64, 64, 0, 0, 0, 1, 0);
      do_req("R13", 4, 7, 64, 5000, 64, 0, 0, 0, 0, 0);
      do_req("R5", 4, 8, 8, 64, 64, 0, 0, 0, 0, 0);
      do_req("R2", 4, 8, 8, 64, 64, 0, 0, 1, 0, 0);
      // R6: size caps per generation
      do_req("R6", 0, 4097, 100, 200, 100, 0, 0, 0, 0, 0);
      do_req("R6", 0, 4096, 100, 200, 100, 0, 0, 0, 0, 0);
      do_req("R6", 1, 5120, 100, 200, 100, 0, 0, 0, 0, 1);
      do_req("R6", 2, 5121, 100, 200, 100, 0, 0, 0, 0, 1);
      do_req("R6", 2, 200, 100, 300, 4097, 0, 0, 0, 0, 1);
      do_req("R6", 2, 200, 100, 5120, 100, 0, 0, 0, 0, 0);
      // R10: reject for a holder keeps its holding
      do_req("R10", 1, 200, 100, 5121, 100, 0, 0, 0, 0, 1);
      // R11: out-of-range users
      do_req("R11", 5, 10, 10, 10, 10, 0, 0, 1, 0, 0);
      do_req("R11", 7, 64, 64, 32, 32, 0, 1, 0, 0, 0);
      // random mix, back-to-back and spaced
      for (int i = 0; i < 600; i++) begin
         int d1, d2, d3, d4;
         d1 = pick_dim(); d2 = pick_dim();
         if ($urandom_range(0, 1)) begin d3 = d1; d4 = d2; end
         else begin d3 = pick_dim(); d4 = pick_dim(); end
         do_req("R13", $urandom_range(0, 6), d1, d2, d3, d4,
                1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0),
                1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 3) == 0),
                1'($urandom_range(0, 1)));
         if ($urandom_range(0, 3) == 0) @(negedge clk);
      end
      @(negedge clk);
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule